// File: doc/BRIEF.md
# Store-and-Forward Packet Gate

This block sits in front of a transmit port that does not tolerate idle cycles inside a packet once the first beat has gone out. Beats arrive on a valid/ready sink, carrying a 64-bit word and an end-of-packet marker. Each accepted beat is written into an internal FIFO. The block does not release a packet downstream until the packet has been stored in full.

A counter tracks how many complete packets are held. It goes up when a beat marked as end-of-packet is written and down when such a beat is read. The source presents valid only while that count is non-zero. Because every counted packet is already in storage, valid then stays high from the first beat to the last, and the only pauses come from the receiver withdrawing ready.

Back-pressure rules. On the sink, a beat transfers on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low only while the FIFO is full. On the source, a beat transfers where `out_valid` and `out_ready` are both high. While `out_ready` is low, the presented beat stays unchanged. The FIFO depth must be a power of two, at least 2, and at least one maximum-size packet. The default is 256 words.

Top module: `pkt_gate`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and `overflow` is 0.
- R2: Beats leave in the order they were accepted. Each keeps its data and its end-of-packet bit.
- R3: `out_valid` is 1 exactly when at least one packet whose end-of-packet beat has been accepted is not yet fully sent. It becomes 1 in the cycle after the edge that accepts such an end-of-packet beat.
- R4: Once the first beat of a packet has transferred, `out_valid` stays 1 in every cycle until that packet's end-of-packet beat has transferred.
- R5: `in_ready` is 0 exactly when DEPTH beats are stored. The FIFO therefore holds DEPTH beats.
- R6: If an end-of-packet beat is accepted on the same edge that another one is sent, the count of complete packets is unchanged.
- R7: `overflow` rises one cycle after the FIFO becomes full while holding no complete packet. It then stays 1 until reset.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sink beat valid |
| in_ready | output | 1 | Sink may accept a beat |
| in_data | input | DATA_W | Sink beat data |
| in_last | input | 1 | Sink beat ends a packet |
| out_valid | output | 1 | Source beat valid |
| out_ready | input | 1 | Receiver accepts the beat |
| out_data | output | DATA_W | Source beat data |
| out_last | output | 1 | Source beat ends a packet |
| overflow | output | 1 | Sticky: a packet did not fit in the FIFO |

## Verification
The results have these latencies:
- The front stored beat appears on `out_data` and `out_last` in the same cycle it becomes the head.
- `out_valid` rises one cycle after the edge that accepts an end-of-packet beat.
- `in_ready` falls one cycle after the edge that stores the DEPTH-th beat.
- `overflow` rises one edge after that.

The bench drives inputs on the falling edge and waits a moment before reading the outputs. Its model works out which handshakes the next rising edge will complete, so each comparison lines up with the cycle in which the result is due.

// File: rtl/pkt_gate_pkg.sv
package pkt_gate_pkg;
  typedef enum logic {
    EG_IDLE = 1'b0,
    EG_BUSY = 1'b1
  } eg_state_t;
endpackage

// File: rtl/pkt_gate_fifo.sv
module pkt_gate_fifo #(
  parameter int W     = 65,
  parameter int DEPTH = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_word,
  input  logic         rd_en,
  output logic [W-1:0] rd_word,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr[AW-1:0]] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_en) wr_ptr <= wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  assign rd_word = mem[rd_ptr[AW-1:0]];
  assign empty   = (wr_ptr == rd_ptr);
  assign full    = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);

  // R5: the sink never writes into a full store
  a_r5_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !wr_en);
  // R3: the source never pulls from an empty store
  a_r3_no_read_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !empty);
endmodule

// File: rtl/pkt_gate_credit.sv
module pkt_gate_credit #(
  parameter int CW = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  input  logic full,
  output logic have_pkt,
  output logic overflow
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      overflow <= 1'b0;
    end else begin
      cnt <= cnt + CW'(inc) - CW'(dec);
      if (full && cnt == '0) overflow <= 1'b1;
    end
  end

  assign have_pkt = (cnt != '0);

  // R6: a release is only possible with a counted packet
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> have_pkt);
  // R6: simultaneous add and release leave the count alone
  a_r6_balanced: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec) |=> $stable(cnt));
  // R7: overflow is sticky
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
endmodule

// File: rtl/pkt_gate_egress.sv
module pkt_gate_egress
  import pkt_gate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic have_pkt,
  input  logic out_ready,
  input  logic head_last,
  output logic out_valid,
  output logic rd_en
);
  eg_state_t state;

  assign out_valid = have_pkt;
  assign rd_en     = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= EG_IDLE;
    end else if (rd_en) begin
      state <= head_last ? EG_IDLE : EG_BUSY;
    end
  end

  // R4: no gap once a packet has started leaving
  a_r4_gapless: assert property (@(posedge clk) disable iff (!rst_n)
    (state == EG_BUSY) |-> out_valid);
endmodule

// File: rtl/pkt_gate.sv
module pkt_gate #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic              overflow
);
  localparam int WW = DATA_W + 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic          wr_en, rd_en, full, empty, have_pkt;
  logic [WW-1:0] head;

  assign in_ready = !full;
  assign wr_en    = in_valid && in_ready;

  pkt_gate_fifo #(.W(WW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_word({in_last, in_data}),
    .rd_en(rd_en), .rd_word(head),
    .full(full), .empty(empty)
  );

  pkt_gate_credit #(.CW(CW)) u_credit (
    .clk(clk), .rst_n(rst_n),
    .inc(wr_en && in_last), .dec(rd_en && head[DATA_W]),
    .full(full), .have_pkt(have_pkt), .overflow(overflow)
  );

  pkt_gate_egress u_egress (
    .clk(clk), .rst_n(rst_n),
    .have_pkt(have_pkt), .out_ready(out_ready), .head_last(head[DATA_W]),
    .out_valid(out_valid), .rd_en(rd_en)
  );

  assign out_data = head[DATA_W-1:0];
  assign out_last = head[DATA_W];

  // R8: a stalled beat holds steady
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
  // R3: a counted packet implies stored words
  a_r3_valid_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !empty);
endmodule

// File: tb/tb_pkt_gate.sv
module tb_pkt_gate;
  localparam int DW = 64;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, out_valid, out_last, overflow;
  logic [DW-1:0] out_data;

  always #10 clk = ~clk;

  pkt_gate #(.DATA_W(DW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .overflow(overflow)
  );

  int checks = 0, errors = 0;
  logic [DW:0] src_q[$];
  logic [DW:0] model[$];
  int credits = 0;
  bit in_pkt = 0, src_rand = 0, snk_rand = 0, snk_on = 1;
  bit prev_stall = 0;
  logic [DW:0] prev_beat;

  task automatic chk(bit ok, string req, logic [DW:0] act, logic [DW:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; in_valid = 0; out_ready = 0;
    src_q.delete(); model.delete();
    credits = 0; in_pkt = 0; prev_stall = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic step();
    @(negedge clk);
    in_valid = (src_q.size() > 0) && (src_rand ? ($urandom % 2 == 1) : 1'b1);
    if (src_q.size() > 0) {in_last, in_data} = src_q[0];
    out_ready = snk_rand ? ($urandom % 2 == 1) : snk_on;
    #1;
    chk(out_valid == (credits > 0), "R3 out_valid vs complete packets", {64'd0, out_valid}, {64'd0, credits > 0});
    chk(in_ready == (model.size() < DEPTH), "R5 in_ready vs occupancy", {64'd0, in_ready}, {64'd0, model.size() < DEPTH});
    if (in_pkt) chk(out_valid, "R4 gap inside packet", {64'd0, out_valid}, 65'd1);
    if (prev_stall) chk({out_last, out_data} == prev_beat, "R8 stalled beat held", {out_last, out_data}, prev_beat);
    if (out_valid && model.size() > 0)
      chk({out_last, out_data} == model[0], "R2 beat order and content", {out_last, out_data}, model[0]);
    prev_stall = out_valid && !out_ready;
    prev_beat = {out_last, out_data};
    if (in_valid && in_ready) begin
      model.push_back(src_q.pop_front());
      if (model[$][DW]) credits++;
    end
    if (out_valid && out_ready && model.size() > 0) begin
      logic [DW:0] b;
      b = model.pop_front();
      if (b[DW]) begin credits--; in_pkt = 0; end
      else in_pkt = 1;
    end
  endtask

  task automatic add_pkt(int len, int tagv);
    for (int i = 0; i < len; i++)
      src_q.push_back({(i == len - 1), DW'((tagv << 16) + (len << 8) + i)});
  endtask

  task automatic drain();
    int guard = 0;
    while ((src_q.size() > 0 || model.size() > 0) && guard < 2000) begin
      step(); guard++;
    end
    chk(guard < 2000, "R2 drain completes", 65'(guard), 65'd2000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    // R1 reset state
    chk(out_valid == 0, "R1 out_valid after reset", {64'd0, out_valid}, 65'd0);
    chk(in_ready == 1, "R1 in_ready after reset", {64'd0, in_ready}, 65'd1);
    chk(overflow == 0, "R1 overflow after reset", {64'd0, overflow}, 65'd0);

    // R2 R3 R4 R5 R8: every length under every handshake pattern
    for (int mode = 0; mode < 4; mode++) begin
      src_rand = mode[0]; snk_rand = mode[1]; snk_on = 1;
      for (int len = 1; len <= DEPTH; len++) begin
        add_pkt(len, mode);
        drain();
      end
      for (int len = 1; len <= DEPTH; len++) add_pkt(len, mode + 4);
      drain();
    end

    // R6: back-to-back single-beat packets, add and release on one edge
    src_rand = 0; snk_rand = 0; snk_on = 1;
    for (int i = 0; i < 20; i++) add_pkt(1, 9);
    drain();
    chk(credits == 0, "R6 count balanced", 65'(credits), 65'd0);

    // R5: fill with stalled sink, then release
    snk_on = 0;
    add_pkt(DEPTH, 10);
    repeat (DEPTH + 2) step();
    chk(in_ready == 0, "R5 full blocks sink", {64'd0, in_ready}, 65'd0);
    chk(overflow == 0, "R7 no overflow with counted packet", {64'd0, overflow}, 65'd0);
    snk_on = 1;
    drain();

    // R7: packet longer than storage
    do_reset();
    src_rand = 0; snk_rand = 0; snk_on = 1;
    add_pkt(DEPTH + 3, 11);
    repeat (DEPTH - 1) step();
    chk(overflow == 0, "R7 not yet full", {64'd0, overflow}, 65'd0);
    repeat (3) step();
    chk(overflow == 1, "R7 overflow raised", {64'd0, overflow}, 65'd1);
    chk(out_valid == 0, "R7 nothing released", {64'd0, out_valid}, 65'd0);
    repeat (5) step();
    chk(overflow == 1, "R7 overflow sticky", {64'd0, overflow}, 65'd1);
    do_reset();
    #1;
    chk(overflow == 0, "R7 cleared by reset", {64'd0, overflow}, 65'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule